// File: doc/BRIEF.md
# Base-and-Bound Address Translator

This block sits between a processor's load/store path and memory, and serves a single running context. It holds two privileged registers: a relocation base and a limit. Each request carries an untranslated address. The block adds the base to that address and, in the same cycle, compares the untranslated address against the limit. A legal access returns the relocated physical address. An illegal access returns a fault, which the processor turns into a trap to the kernel.

Supervisor software reloads both registers on every context switch through a write port that is gated by a privilege qualifier. A write presented without privilege changes nothing. To move a process in memory, software rewrites only the base. The program's own addresses stay as they were. The response is registered, so each accepted request yields exactly one response on the following cycle.

Top module: `bb_xlate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rsp_valid` is 0. After reset the limit is 0 and the base is 0, so every request faults until software writes the registers.
- R2: A request whose address `a` satisfies `a < limit` and `a + base < 2^32` produces `rsp_fault`=0 and `rsp_paddr = a + base`.
- R3: A request with `a >= limit` produces `rsp_fault`=1. This includes `a` equal to the limit.
- R4: A request for which `a + base` carries out of bit 31 produces `rsp_fault`=1, even when `a < limit`.
- R5: `rsp_valid` is 1 in the cycle after a cycle with `req_valid`=1, and 0 in the cycle after a cycle with `req_valid`=0.
- R6: A faulting response drives `rsp_paddr` to 0, so the block never returns an address and a fault together.
- R7: A write with `cfg_we`=1 and `cfg_priv`=0 is ignored. It changes neither the base nor the limit.
- R8: A privileged write to `cfg_sel`=0 loads the base, and to `cfg_sel`=1 loads the limit. A request in the same cycle as the write is translated with the old values. Later requests use the new values.
- R9: Rewriting only the base relocates an unchanged untranslated address to a new physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_priv | input | 1 | 1 when the writer runs in supervisor mode |
| cfg_sel | input | 1 | 0 selects the base, 1 selects the limit |
| cfg_wdata | input | AW | Write data |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | AW | Untranslated address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 1 | Access is illegal; trap |
| rsp_paddr | output | AW | Physical address; 0 on a fault |

## Verification
The table drives in-range addresses, the last legal address, an address equal to the limit, and sums that carry out of bit 31. Together these separate a correct strict-less-than compare from an off-by-one compare, and the carry fault from the limit fault. A full-range limit with a zero base shows that the add is an identity when it should be. Directed cases cover the rest. The reset limit faults even address 0. An unprivileged write is shown to leave both the result and the fault unchanged. A write in the same cycle as a request shows that the old register values apply. A base change applied to a fixed address shows relocation.

// File: rtl/bb_xlate.sv
module bb_xlate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_priv,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  output logic          rsp_valid,
  output logic          rsp_fault,
  output logic [AW-1:0] rsp_paddr
);
  logic [AW-1:0] base_q, limit_q;
  logic [AW:0]   sum;
  logic          over_limit, carry, bad;
  logic          wr_ok;

  assign wr_ok      = cfg_we && cfg_priv;
  assign sum        = {1'b0, req_vaddr} + {1'b0, base_q};
  assign over_limit = !(req_vaddr < limit_q);
  assign carry      = sum[AW];
  assign bad        = over_limit || carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (wr_ok) begin
      if (cfg_sel) limit_q <= cfg_wdata;
      else         base_q  <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && bad;
      rsp_paddr <= (req_valid && !bad) ? sum[AW-1:0] : '0;
    end
  end
endmodule

module bb_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          cfg_priv,
  input logic          req_valid,
  input logic [AW-1:0] req_vaddr,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] limit_q,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic [AW-1:0] rsp_paddr
);
  p_rsp_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_fault_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
  p_limit_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_vaddr >= limit_q)) |=> rsp_fault);
  p_carry_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_vaddr} + {1'b0, base_q} > {1'b0, {AW{1'b1}}})) |=> rsp_fault);
  p_user_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_priv) |=> ($stable(base_q) && $stable(limit_q)));
  p_legal_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_vaddr < limit_q) && ({1'b0, req_vaddr} + {1'b0, base_q} <= {1'b0, {AW{1'b1}}}))
    |=> (!rsp_fault && rsp_paddr == $past(req_vaddr + base_q)));
endmodule

bind bb_xlate bb_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
  .req_valid(req_valid), .req_vaddr(req_vaddr), .base_q(base_q),
  .limit_q(limit_q), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr)
);

// File: tb/bb_xlate_test.sv
module bb_xlate_test;
  localparam int AW = 32;
  localparam int NV = 7;
  // {base, limit, vaddr, fault, paddr}
  localparam logic [4*AW:0] VEC [NV] = '{
    {32'h0000_1000, 32'h0000_0100, 32'h0000_0010, 1'b0, 32'h0000_1010},
    {32'h0000_1000, 32'h0000_0100, 32'h0000_00FF, 1'b0, 32'h0000_10FF},
    {32'h0000_1000, 32'h0000_0100, 32'h0000_0100, 1'b1, 32'h0000_0000},
    {32'hFFFF_F000, 32'h0000_2000, 32'h0000_0FFF, 1'b0, 32'hFFFF_FFFF},
    {32'hFFFF_F000, 32'h0000_2000, 32'h0000_1000, 1'b1, 32'h0000_0000},
    {32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1, 32'h0000_0000},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_1234, 1'b0, 32'h0000_1234}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_priv = 0, cfg_sel = 0, req_valid = 0;
  logic [AW-1:0] cfg_wdata = '0, req_vaddr = '0;
  logic rsp_valid, rsp_fault;
  logic [AW-1:0] rsp_paddr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bb_xlate #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
  );

  task automatic check(input string tag, input logic f, input logic [AW-1:0] pa);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_fault !== f || rsp_paddr !== pa) begin
      errors++;
      $display("FAIL %s: got v=%b f=%b pa=%h, expected v=1 f=%b pa=%h",
               tag, rsp_valid, rsp_fault, rsp_paddr, f, pa);
    end
  endtask

  task automatic wr(input logic priv, input logic sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_priv = priv; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_priv = 0;
  endtask

  task automatic req(input logic [AW-1:0] va);
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    @(posedge clk); #1;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R1: got rsp_valid=%b, expected 0", rsp_valid);
    end
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R1: got rsp_valid=%b after reset, expected 0", rsp_valid);
    end

    // R1: limit is 0 out of reset, address 0 faults
    req(32'h0);
    check("R1 reset limit", 1'b1, '0);

    // R2 R3 R4 R6 table
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, 1'b0, VEC[i][4*AW:3*AW+1]);
      wr(1'b1, 1'b1, VEC[i][3*AW:2*AW+1]);
      req(VEC[i][2*AW:AW+1]);
      check($sformatf("R2/R3/R4/R6 vector %0d", i), VEC[i][AW], VEC[i][AW-1:0]);
    end

    // R5: no request, no response
    @(negedge clk); @(posedge clk); #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R5: got rsp_valid=%b, expected 0", rsp_valid);
    end

    // R7: unprivileged writes ignored (base 0, limit FFFFFFFF stay)
    wr(1'b0, 1'b1, 32'h0000_0010);
    wr(1'b0, 1'b0, 32'h0000_5000);
    req(32'h0000_0020);
    check("R7 user write ignored", 1'b0, 32'h0000_0020);

    // R9: relocation by base only
    wr(1'b1, 1'b0, 32'h0004_0000);
    req(32'h0000_0020);
    check("R9 relocated", 1'b0, 32'h0004_0020);

    // R8: write and request in the same cycle use old values
    @(negedge clk);
    cfg_we = 1; cfg_priv = 1; cfg_sel = 0; cfg_wdata = 32'h0009_0000;
    req_valid = 1; req_vaddr = 32'h0000_0030;
    @(posedge clk); #1;
    check("R8 same-cycle old base", 1'b0, 32'h0004_0030);
    @(negedge clk);
    cfg_we = 0; cfg_priv = 0;
    @(posedge clk); #1;
    check("R8 new base next cycle", 1'b0, 32'h0009_0030);
    @(negedge clk); req_valid = 0;

    // R8: limit write takes effect
    wr(1'b1, 1'b1, 32'h0000_0030);
    req(32'h0000_0030);
    check("R8 new limit", 1'b1, '0);
    req(32'h0000_002F);
    check("R8 below new limit", 1'b0, 32'h0009_002F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule